// File: doc/BRIEF.md
# Fitted-Track Trigger Selector

This block sits after a track fitter and turns one event's worth of fitted tracks into a single accept or reject decision. Tracks arrive one per cycle. Each carries a transverse momentum, a chi-square fit quality and a valid flag. An end-of-event strobe closes the event, and it may come on the same cycle as the last track. Tracks whose chi-square does not fall below a programmable cut are treated as failed fits and play no part.

Two selection strategies are available. The first keeps the highest-momentum track of the event. The second keeps the two tracks with the lowest chi-square and then takes whichever of that pair has the higher momentum. The chosen track is compared with a programmable momentum threshold to form the decision.

The strategy, the cut and the threshold are captured on the first cycle of each event and held until that event ends. The decision, the chosen track and a one-cycle valid strobe appear on the cycle after the end strobe. All per-event state is cleared at the same time, so a new event may begin on that very cycle.

Top module: `trksel_top`

## Requirements
- R1: After reset, `dec_valid`, `dec_accept` and `sel_found` are 0, and `sel_pt` and `sel_chi` are 0.
- R2: A track takes part in selection only if `trk_valid` is 1 and `trk_chi` is strictly less than the event's chi-square cut. All other tracks are ignored, even when their momentum is higher.
- R3: With mode 0, the chosen track is the qualifying track with the highest `trk_pt`. On equal momentum, the earlier-arriving track wins.
- R4: With mode 1, the block first forms the pair of qualifying tracks with the lowest chi-square. On equal chi-square, the earlier-arriving track ranks better. The chosen track is the member of that pair with the higher momentum. On equal momentum, the member with the better chi-square rank wins.
- R5: With mode 1 and exactly one qualifying track, that track is chosen.
- R6: With no qualifying track, the decision is reject: `sel_found`=0, `dec_accept`=0, and `sel_pt` and `sel_chi` are 0.
- R7: `dec_accept` is 1 exactly when a track was chosen and its `sel_pt` is greater than or equal to the event's momentum threshold.
- R8: `dec_valid` is 1 for exactly the one cycle that follows a cycle with `evt_end`=1. A track presented on the same cycle as `evt_end` belongs to the ending event.
- R9: The mode, cut and threshold are sampled on the first cycle of an event. That is the first cycle with `trk_valid` or `evt_end` high after reset or after an end strobe. Changes to these inputs later in the event have no effect on that event.
- R10: Per-event state is cleared at the end strobe, so an event that starts on the cycle right after `evt_end` is judged only on its own tracks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 1 | Strategy: 0 highest momentum, 1 best chi-square pair |
| cfg_chi_cut | input | CHI_W | Chi-square cut (a track must be strictly below it) |
| cfg_pt_thr | input | PT_W | Momentum threshold for accept |
| trk_valid | input | 1 | Track present this cycle |
| trk_pt | input | PT_W | Track transverse momentum, unsigned |
| trk_chi | input | CHI_W | Track chi-square, unsigned |
| evt_end | input | 1 | End of event strobe |
| dec_valid | output | 1 | Decision strobe, one cycle |
| dec_accept | output | 1 | Trigger accept |
| sel_found | output | 1 | A qualifying track was chosen |
| sel_pt | output | PT_W | Momentum of the chosen track |
| sel_chi | output | CHI_W | Chi-square of the chosen track |

## Verification
The bench builds the block with its default parameters: 12-bit momentum, 8-bit chi-square and the pair strategy present. With these values, cuts near 40 and thresholds across the 4 to 28 range can be set directly. Ties in both momentum and chi-square can be forced with small integers. A bench model ranks each event on its own, and the bench compares the result for both modes. The cases covered include boundary values at the cut and at the threshold, settings changed in the middle of an event, and events that follow one another with no idle cycle.

// File: rtl/trksel_pkg.sv
package trksel_pkg;
   typedef enum logic {
      SEL_MAX_PT   = 1'b0,
      SEL_PAIR_CHI = 1'b1
   } sel_mode_e;
endpackage

// File: rtl/trksel_gate.sv
module trksel_gate #(
   parameter int CHI_W = 8
) (
   input  logic             in_valid,
   input  logic [CHI_W-1:0] in_chi,
   input  logic [CHI_W-1:0] chi_cut,
   output logic             take
);
   // R2: strict comparison against the cut
   always_comb take = in_valid && (in_chi < chi_cut);
endmodule

// File: rtl/trksel_maxpt.sv
module trksel_maxpt #(
   parameter int PT_W  = 12,
   parameter int CHI_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             clr,
   input  logic [PT_W-1:0]  in_pt,
   input  logic [CHI_W-1:0] in_chi,
   output logic             nxt_have,
   output logic [PT_W-1:0]  nxt_pt,
   output logic [CHI_W-1:0] nxt_chi
);
   logic             have_q;
   logic [PT_W-1:0]  pt_q;
   logic [CHI_W-1:0] chi_q;
   logic             repl;

   // strict greater: an equal later track loses (R3)
   always_comb begin
      repl     = take && (!have_q || (in_pt > pt_q));
      nxt_have = have_q || take;
      nxt_pt   = repl ? in_pt  : pt_q;
      nxt_chi  = repl ? in_chi : chi_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         have_q <= 1'b0;
         pt_q   <= '0;
         chi_q  <= '0;
      end else begin
         have_q <= nxt_have;
         pt_q   <= nxt_pt;
         chi_q  <= nxt_chi;
      end
   end

   a_r3_max_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      (have_q && !clr) |=> (have_q && pt_q >= $past(pt_q)));
endmodule

// File: rtl/trksel_pair.sv
module trksel_pair #(
   parameter int PT_W  = 12,
   parameter int CHI_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             clr,
   input  logic [PT_W-1:0]  in_pt,
   input  logic [CHI_W-1:0] in_chi,
   output logic             nxt_have,
   output logic [PT_W-1:0]  nxt_pt,
   output logic [CHI_W-1:0] nxt_chi
);
   logic             h1_q, h2_q, h1_n, h2_n;
   logic [PT_W-1:0]  p1_q, p2_q, p1_n, p2_n;
   logic [CHI_W-1:0] c1_q, c2_q, c1_n, c2_n;

   // rank by chi-square, strict less so earlier tracks keep their place (R4)
   always_comb begin
      h1_n = h1_q; p1_n = p1_q; c1_n = c1_q;
      h2_n = h2_q; p2_n = p2_q; c2_n = c2_q;
      if (take) begin
         if (!h1_q || (in_chi < c1_q)) begin
            h2_n = h1_q; p2_n = p1_q; c2_n = c1_q;
            h1_n = 1'b1; p1_n = in_pt; c1_n = in_chi;
         end else if (!h2_q || (in_chi < c2_q)) begin
            h2_n = 1'b1; p2_n = in_pt; c2_n = in_chi;
         end
      end
      nxt_have = h1_n;
      // R4/R5: second member only wins on strictly higher momentum
      if (h2_n && (p2_n > p1_n)) begin
         nxt_pt  = p2_n;
         nxt_chi = c2_n;
      end else begin
         nxt_pt  = p1_n;
         nxt_chi = c1_n;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         h1_q <= 1'b0; p1_q <= '0; c1_q <= '0;
         h2_q <= 1'b0; p2_q <= '0; c2_q <= '0;
      end else begin
         h1_q <= h1_n; p1_q <= p1_n; c1_q <= c1_n;
         h2_q <= h2_n; p2_q <= p2_n; c2_q <= c2_n;
      end
   end

   a_r4_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
      h2_q |-> (h1_q && (c1_q <= c2_q)));
endmodule

// File: rtl/trksel_top.sv
module trksel_top #(
   parameter int PT_W     = 12,
   parameter int CHI_W    = 8,
   parameter bit HAS_PAIR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_mode,
   input  logic [CHI_W-1:0] cfg_chi_cut,
   input  logic [PT_W-1:0]  cfg_pt_thr,
   input  logic             trk_valid,
   input  logic [PT_W-1:0]  trk_pt,
   input  logic [CHI_W-1:0] trk_chi,
   input  logic             evt_end,
   output logic             dec_valid,
   output logic             dec_accept,
   output logic             sel_found,
   output logic [PT_W-1:0]  sel_pt,
   output logic [CHI_W-1:0] sel_chi
);
   import trksel_pkg::*;

   if (PT_W < 2)  begin : g_bad_pt  $error("PT_W too small");  end
   if (CHI_W < 2) begin : g_bad_chi $error("CHI_W too small"); end

   logic             in_evt_q, start;
   sel_mode_e        mode_q, mode_e;
   logic [CHI_W-1:0] cut_q, cut_e;
   logic [PT_W-1:0]  thr_q, thr_e;
   logic             take;

   // R9: settings come from the ports on the first cycle, then from the latch
   always_comb begin
      start  = !in_evt_q && (trk_valid || evt_end);
      mode_e = in_evt_q ? mode_q : sel_mode_e'(cfg_mode);
      cut_e  = in_evt_q ? cut_q  : cfg_chi_cut;
      thr_e  = in_evt_q ? thr_q  : cfg_pt_thr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_evt_q <= 1'b0;
         mode_q   <= SEL_MAX_PT;
         cut_q    <= '0;
         thr_q    <= '0;
      end else begin
         if (evt_end)    in_evt_q <= 1'b0;
         else if (start) in_evt_q <= 1'b1;
         if (start) begin
            mode_q <= sel_mode_e'(cfg_mode);
            cut_q  <= cfg_chi_cut;
            thr_q  <= cfg_pt_thr;
         end
      end
   end

   trksel_gate #(.CHI_W(CHI_W)) u_gate (
      .in_valid(trk_valid), .in_chi(trk_chi), .chi_cut(cut_e), .take(take)
   );

   logic             a_have;
   logic [PT_W-1:0]  a_pt;
   logic [CHI_W-1:0] a_chi;

   trksel_maxpt #(.PT_W(PT_W), .CHI_W(CHI_W)) u_maxpt (
      .clk(clk), .rst_n(rst_n), .take(take), .clr(evt_end),
      .in_pt(trk_pt), .in_chi(trk_chi),
      .nxt_have(a_have), .nxt_pt(a_pt), .nxt_chi(a_chi)
   );

   logic             r_have;
   logic [PT_W-1:0]  r_pt;
   logic [CHI_W-1:0] r_chi;

   if (HAS_PAIR) begin : g_pair
      logic             b_have;
      logic [PT_W-1:0]  b_pt;
      logic [CHI_W-1:0] b_chi;

      trksel_pair #(.PT_W(PT_W), .CHI_W(CHI_W)) u_pair (
         .clk(clk), .rst_n(rst_n), .take(take), .clr(evt_end),
         .in_pt(trk_pt), .in_chi(trk_chi),
         .nxt_have(b_have), .nxt_pt(b_pt), .nxt_chi(b_chi)
      );

      always_comb begin
         if (mode_e == SEL_PAIR_CHI) begin
            r_have = b_have; r_pt = b_pt; r_chi = b_chi;
         end else begin
            r_have = a_have; r_pt = a_pt; r_chi = a_chi;
         end
      end
   end else begin : g_single
      always_comb begin
         r_have = a_have; r_pt = a_pt; r_chi = a_chi;
      end
   end

   // R8: result registered on the end strobe
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_accept <= 1'b0;
         sel_found  <= 1'b0;
         sel_pt     <= '0;
         sel_chi    <= '0;
      end else begin
         dec_valid <= evt_end;
         if (evt_end) begin
            sel_found  <= r_have;
            sel_pt     <= r_pt;
            sel_chi    <= r_chi;
            dec_accept <= r_have && (r_pt >= thr_e);
         end
      end
   end

   a_r7_accept_thr: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dec_accept) |-> (sel_found && (sel_pt >= $past(thr_e))));

   a_r2_found_below_cut: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_end && r_have) |=> (sel_chi < $past(cut_e)));

   a_r6_none_rejects: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !sel_found) |-> (!dec_accept && sel_pt == '0 && sel_chi == '0));
endmodule

// File: tb/tb_trksel_top.sv
module tb_trksel_top;
   localparam int PT_W  = 12;
   localparam int CHI_W = 8;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             cfg_mode;
   logic [CHI_W-1:0] cfg_chi_cut;
   logic [PT_W-1:0]  cfg_pt_thr;
   logic             trk_valid;
   logic [PT_W-1:0]  trk_pt;
   logic [CHI_W-1:0] trk_chi;
   logic             evt_end;
   logic             dec_valid, dec_accept, sel_found;
   logic [PT_W-1:0]  sel_pt;
   logic [CHI_W-1:0] sel_chi;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   trksel_top #(.PT_W(PT_W), .CHI_W(CHI_W), .HAS_PAIR(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_chi_cut(cfg_chi_cut),
      .cfg_pt_thr(cfg_pt_thr), .trk_valid(trk_valid), .trk_pt(trk_pt),
      .trk_chi(trk_chi), .evt_end(evt_end), .dec_valid(dec_valid),
      .dec_accept(dec_accept), .sel_found(sel_found), .sel_pt(sel_pt),
      .sel_chi(sel_chi)
   );

   // event description
   int   ev_n;
   logic ev_v   [8];
   int   ev_pt  [8];
   int   ev_chi [8];

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // bench model of the ranking rules
   task automatic model(input int mode, input int cut, input int thr,
                        output int found, output int pt, output int chi, output int acc);
      int b1, b2, s;
      b1 = -1; b2 = -1; s = -1;
      for (int i = 0; i < ev_n; i++) begin
         if (ev_v[i] && ev_chi[i] < cut) begin
            if (mode == 0) begin
               if (s < 0 || ev_pt[i] > ev_pt[s]) s = i;
            end else begin
               if (b1 < 0 || ev_chi[i] < ev_chi[b1]) b1 = i;
            end
         end
      end
      if (mode == 1) begin
         for (int i = 0; i < ev_n; i++)
            if (i != b1 && ev_v[i] && ev_chi[i] < cut)
               if (b2 < 0 || ev_chi[i] < ev_chi[b2]) b2 = i;
         s = b1;
         if (b2 >= 0 && ev_pt[b2] > ev_pt[b1]) s = b2;
      end
      found = (s >= 0);
      pt    = found ? ev_pt[s]  : 0;
      chi   = found ? ev_chi[s] : 0;
      acc   = found && (pt >= thr);
   endtask

   task automatic idle();
      trk_valid = 1'b0; trk_pt = '0; trk_chi = '0; evt_end = 1'b0;
   endtask

   // drive one event; if alt, ports change after the first cycle (R9)
   task automatic run_event(input string tag, input int mode, input int cut,
                            input int thr, input bit alt);
      int f, p, c, a;
      model(mode, cut, thr, f, p, c, a);
      @(negedge clk);
      cfg_mode = mode[0]; cfg_chi_cut = cut[CHI_W-1:0]; cfg_pt_thr = thr[PT_W-1:0];
      if (ev_n == 0) begin
         idle(); evt_end = 1'b1;
      end else begin
         for (int i = 0; i < ev_n; i++) begin
            if (i > 0) @(negedge clk);
            if (i == 1 && alt) begin
               cfg_mode = ~mode[0]; cfg_chi_cut = '1; cfg_pt_thr = '0;
            end
            trk_valid = ev_v[i];
            trk_pt    = ev_pt[i][PT_W-1:0];
            trk_chi   = ev_chi[i][CHI_W-1:0];
            evt_end   = (i == ev_n - 1);
         end
      end
      @(negedge clk);
      idle();
      chk({tag, " R8 valid"}, dec_valid, 1);
      chk({tag, " found"}, sel_found, f);
      chk({tag, " pt"}, sel_pt, p);
      chk({tag, " chi"}, sel_chi, c);
      chk({tag, " R7 accept"}, dec_accept, a);
      @(negedge clk);
      chk({tag, " R8 one cycle"}, dec_valid, 0);
   endtask

   task automatic set3(input int p0, c0, p1, c1, p2, c2);
      ev_n = 3;
      ev_v[0] = 1; ev_pt[0] = p0; ev_chi[0] = c0;
      ev_v[1] = 1; ev_pt[1] = p1; ev_chi[1] = c1;
      ev_v[2] = 1; ev_pt[2] = p2; ev_chi[2] = c2;
   endtask

   task automatic t_reset();
      chk("R1 dec_valid", dec_valid, 0);
      chk("R1 accept", dec_accept, 0);
      chk("R1 found", sel_found, 0);
      chk("R1 pt", sel_pt, 0);
      chk("R1 chi", sel_chi, 0);
   endtask

   task automatic t_mode_a();
      set3(10, 30, 25, 20, 18, 5);
      run_event("R3 maxpt", 0, 40, 20, 0);
      set3(15, 30, 15, 5, 9, 1);      // pT tie, earlier wins
      run_event("R3 tie", 0, 40, 4, 0);
   endtask

   task automatic t_mode_b();
      set3(30, 35, 12, 3, 20, 8);     // pair chi 3,8 -> pt 20
      run_event("R4 pair", 1, 40, 18, 0);
      set3(30, 6, 12, 6, 20, 6);      // chi tie: first two, pt 30
      run_event("R4 chi tie", 1, 40, 25, 0);
      set3(11, 9, 11, 4, 50, 30);     // pt tie in pair -> better chi (4)
      run_event("R4 pt tie", 1, 40, 4, 0);
   endtask

   task automatic t_cut();
      set3(90, 40, 22, 39, 60, 3);
      ev_v[2] = 0;                    // invalid, high pt
      run_event("R2 cut mode0", 0, 40, 22, 0);
      set3(90, 40, 22, 39, 60, 3);
      ev_v[2] = 0;
      run_event("R5 single mode1", 1, 40, 23, 0);
   endtask

   task automatic t_none();
      set3(90, 41, 80, 40, 70, 200);
      run_event("R6 none mode1", 1, 40, 4, 0);
      ev_n = 0;
      run_event("R6 empty", 0, 40, 4, 0);
   endtask

   task automatic t_cfg_mid();
      set3(28, 10, 5, 2, 40, 45);     // later ports: mode flip, cut max, thr 0
      run_event("R9 mode0", 0, 40, 28, 1);
      set3(28, 10, 5, 2, 40, 45);
      run_event("R9 mode1", 1, 40, 6, 1);
   endtask

   task automatic t_back_to_back();
      // event 1: pt 50; event 2 starts next cycle with pt 7 only (R10)
      @(negedge clk);
      cfg_mode = 1'b0; cfg_chi_cut = 8'd40; cfg_pt_thr = 12'd10;
      trk_valid = 1'b1; trk_pt = 12'd50; trk_chi = 8'd5; evt_end = 1'b1;
      @(negedge clk);
      trk_valid = 1'b1; trk_pt = 12'd7; trk_chi = 8'd5; evt_end = 1'b1;
      chk("R10 first valid", dec_valid, 1);
      chk("R10 first pt", sel_pt, 50);
      chk("R10 first accept", dec_accept, 1);
      @(negedge clk);
      idle();
      chk("R10 second valid", dec_valid, 1);
      chk("R10 second pt", sel_pt, 7);
      chk("R10 second accept", dec_accept, 0);
      @(negedge clk);
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      cfg_mode = 1'b0; cfg_chi_cut = 8'd40; cfg_pt_thr = '0;
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mode_a();
      t_mode_b();
      t_cut();
      t_none();
      t_cfg_mid();
      t_back_to_back();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule